// File: doc/BRIEF.md
# USB Device OUT Endpoint Control

This block holds the control state of one non-zero OUT endpoint of a USB device controller and picks the handshake the packet engine returns when a packet arrives for that endpoint. Software reaches it through a single command/status word. That word has write-one-to-set and write-one-to-clear command bits, plus plain read/write fields for the endpoint kind and the STALL flag. The packet engine reaches it through single-cycle event strobes: SETUP received, transfer complete, disable finished, and a good data packet accepted. Each strobe carries the PID of the data packet it refers to.

The block keeps the enable, disable-request, NAK, STALL and data-PID (or frame-parity) bits. Hardware events force NAK on, drop the enable and drop the disable request, and each event raises an interrupt pulse one cycle later. A combinational handshake select tells the packet engine whether the current packet gets no handshake, ACK, NAK or STALL. A keep strobe tells it whether to store the data of an arriving packet. On bulk, interrupt and control endpoints the same two command bits force DATA0 or DATA1. On isochronous endpoints they force even or odd frame parity.

Command word layout, both directions: bit 0 enable (write 1 sets, reads state), bit 1 disable request (write 1 sets, reads state), bit 2 NAK-set command, bit 3 NAK-clear command, bit 4 STALL (read/write), bit 5 force DATA0/even, bit 6 force DATA1/odd, bit 7 NAK status (read only), bits 9:8 endpoint kind (0 control, 1 isochronous, 2 bulk, 3 interrupt), bit 10 PID/parity status (0 = DATA0 or even, 1 = DATA1 or odd; read only). Bits 2, 3, 5, 6 and all bits above 10 read as 0. Every write loads the kind and STALL fields.

Top module: `usb_oep_ctrl`

## Requirements
- R1: After reset the status word reads 0 (control kind, not enabled, no NAK, no STALL, DATA0), all interrupt and keep outputs are 0, and the handshake select is NAK (code 2).
- R2: Writing 1 to bit 0 sets the enable, and writing 0 there leaves it unchanged. A SETUP, transfer-complete or disable-done strobe clears the enable on the next edge. That same edge raises the matching one-cycle interrupt, so the enable already reads 0 when the interrupt is high.
- R3: Writing 1 to bit 1 sets the disable request only while the endpoint is enabled and no clearing event arrives in the same cycle; otherwise it is ignored. The disable-done strobe clears both the request and the enable on the edge that raises the endpoint-disabled interrupt.
- R4: Writing 1 to bit 2 sets NAK and writing 1 to bit 3 clears it. When both are written together, NAK ends up set. Both command bits read back as 0.
- R5: A SETUP or transfer-complete strobe sets NAK. This also holds when a NAK-clear command is written in the same cycle.
- R6: STALL is stored from bit 4 only when the kind written in the same word is bulk or interrupt; on other kinds it reads 0. While STALL is set the handshake select is STALL (code 3), even with endpoint NAK or global OUT NAK set.
- R7: Handshake select codes are 0 none, 1 ACK, 2 NAK, 3 STALL. An isochronous endpoint always selects none. Otherwise the order is STALL, then NAK (endpoint NAK, global OUT NAK input, or endpoint not enabled), then ACK.
- R8: On non-isochronous kinds, writing bit 6 forces the expected PID to DATA1 and writing bit 5 forces DATA0. When both are written, the result is DATA0. A command write outranks a toggle in the same cycle.
- R9: On an isochronous endpoint, bits 6 and 5 force the frame parity to odd and even. Accepted data never changes the parity, and data is kept whenever the endpoint is enabled.
- R10: A data strobe on a non-isochronous endpoint whose handshake is ACK and whose PID matches the expected one raises keep and toggles the expected PID. A mismatched PID raises no keep and leaves the PID unchanged. Under NAK or STALL, keep stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Command word write strobe |
| cfg_wdata | input | REG_W | Command word write data |
| cfg_rdata | output | REG_W | Status word read data |
| glb_out_nak | input | 1 | Device-wide OUT NAK request |
| ev_setup | input | 1 | SETUP packet received strobe |
| ev_xfer_done | input | 1 | Transfer complete strobe |
| ev_dis_done | input | 1 | Endpoint disable finished strobe |
| ev_data_ok | input | 1 | Good data packet arrived strobe |
| pkt_pid | input | 1 | PID of arriving data packet (0 DATA0, 1 DATA1) |
| ep_enabled | output | 1 | Endpoint enable state |
| ep_dis_pending | output | 1 | Disable request pending |
| ep_nak | output | 1 | Endpoint NAK state |
| ep_stall | output | 1 | Endpoint STALL state |
| ep_pid | output | 1 | Expected data PID or frame parity |
| hs_sel | output | 2 | Handshake select: 0 none, 1 ACK, 2 NAK, 3 STALL |
| data_keep | output | 1 | Store data of the arriving packet |
| irq_setup | output | 1 | SETUP stage interrupt pulse |
| irq_xfer_done | output | 1 | Transfer complete interrupt pulse |
| irq_ep_dis | output | 1 | Endpoint disabled interrupt pulse |

## Verification
The bench targets the same-cycle collisions. In one case a SETUP strobe lands together with a NAK-clear write; a design that let software win would leave the endpoint ACKing. In another both NAK commands or both PID commands are written together; a wrong order would show the opposite NAK or PID. It also sends a repeated PID after an ACK. A design that toggled on every accepted packet would lose sync with the host and keep a duplicate. The remaining cases are STALL written on isochronous or control kinds, STALL combined with every NAK source, a disable request written while disabled, and data on an isochronous endpoint. Getting any of these wrong shows up as a wrong handshake code or a wrong parity bit.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_t;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_t;

  // Command/status word bit positions
  localparam int B_ENA     = 0;
  localparam int B_DIS     = 1;
  localparam int B_NAKSET  = 2;
  localparam int B_NAKCLR  = 3;
  localparam int B_STALL   = 4;
  localparam int B_PID0    = 5;
  localparam int B_PID1    = 6;
  localparam int B_NAKST   = 7;
  localparam int B_KIND    = 8;
  localparam int KIND_W    = 2;
  localparam int B_PIDST   = 10;
  localparam int FIELD_TOP = 10;

  typedef struct packed {
    logic     wr;
    logic     ena_set;
    logic     dis_set;
    logic     nak_set;
    logic     nak_clr;
    logic     pid0_set;
    logic     pid1_set;
    logic     stall_val;
    ep_kind_t kind;
  } sw_cmd_t;

  typedef struct packed {
    logic     ena;
    logic     dis;
    logic     nak;
    logic     stall;
    logic     pid;
    ep_kind_t kind;
  } ep_state_t;

  function automatic logic kind_stallable(ep_kind_t k);
    return (k == EP_BULK) || (k == EP_INTR);
  endfunction

endpackage

// File: rtl/oep_reg_if.sv
module oep_reg_if
  import usb_oep_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  ep_state_t        st,
  output sw_cmd_t          cmd,
  output logic [REG_W-1:0] rdata
);

  localparam int SPARE_W = REG_W - FIELD_TOP - 1;

  always_comb begin
    cmd.wr        = wr_en;
    cmd.ena_set   = wr_en & wdata[B_ENA];
    cmd.dis_set   = wr_en & wdata[B_DIS];
    cmd.nak_set   = wr_en & wdata[B_NAKSET];
    cmd.nak_clr   = wr_en & wdata[B_NAKCLR];
    cmd.pid0_set  = wr_en & wdata[B_PID0];
    cmd.pid1_set  = wr_en & wdata[B_PID1];
    cmd.kind      = ep_kind_t'(wdata[B_KIND +: KIND_W]);
    cmd.stall_val = wdata[B_STALL] & kind_stallable(cmd.kind);
  end

  // Status bits and read-only fields are not write sources
  logic unused_wbits;
  generate
    if (SPARE_W > 0) begin : g_spare
      assign unused_wbits = ^{wdata[B_NAKST], wdata[B_PIDST], wdata[REG_W-1:FIELD_TOP+1]};
    end else begin : g_nospare
      assign unused_wbits = ^{wdata[B_NAKST], wdata[B_PIDST]};
    end
  endgenerate

  always_comb begin
    rdata                    = '0;
    rdata[B_ENA]             = st.ena;
    rdata[B_DIS]             = st.dis;
    rdata[B_STALL]           = st.stall;
    rdata[B_NAKST]           = st.nak;
    rdata[B_KIND +: KIND_W]  = st.kind;
    rdata[B_PIDST]           = st.pid;
  end

  // R4: command bits never read back
  always_comb begin
    assert_cmd_bits_zero_R4: assert (rdata[B_NAKSET] == 1'b0 && rdata[B_NAKCLR] == 1'b0 &&
                                     rdata[B_PID0] == 1'b0 && rdata[B_PID1] == 1'b0);
  end

endmodule

// File: rtl/oep_hs_sel.sv
module oep_hs_sel
  import usb_oep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ep_state_t st,
  input  logic      glb_out_nak,
  output hs_t       hs
);

  logic nak_any;

  always_comb begin
    nak_any = st.nak | glb_out_nak | ~st.ena;
    if (st.kind == EP_ISO)      hs = HS_NONE;
    else if (st.stall)          hs = HS_STALL;
    else if (nak_any)           hs = HS_NAK;
    else                        hs = HS_ACK;
  end

  assert_stall_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st.stall |-> hs == HS_STALL);

  assert_iso_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.kind == EP_ISO) |-> hs == HS_NONE);

  assert_ack_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == HS_ACK) |-> (st.ena && !st.nak && !glb_out_nak));

endmodule

// File: rtl/oep_state.sv
module oep_state
  import usb_oep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sw_cmd_t   cmd,
  input  logic      ev_setup,
  input  logic      ev_xfer_done,
  input  logic      ev_dis_done,
  input  logic      ev_data_ok,
  input  logic      pkt_pid,
  input  hs_t       hs,
  output ep_state_t st,
  output logic      irq_setup,
  output logic      irq_xfer_done,
  output logic      irq_ep_dis,
  output logic      data_keep
);

  ep_state_t st_q, st_n;
  logic      irq_s_q, irq_x_q, irq_d_q;
  logic      ev_clr, pid_match, pid_toggle, st_en, irq_en;

  always_comb begin
    ev_clr     = ev_setup | ev_xfer_done | ev_dis_done;
    pid_match  = (pkt_pid == st_q.pid);
    if (st_q.kind == EP_ISO) begin
      data_keep  = ev_data_ok & st_q.ena;
      pid_toggle = 1'b0;
    end else begin
      data_keep  = ev_data_ok & (hs == HS_ACK) & pid_match;
      pid_toggle = data_keep;
    end
  end

  always_comb begin
    st_n = st_q;
    // enable: hardware clear outranks software set
    if (ev_clr)              st_n.ena = 1'b0;
    else if (cmd.ena_set)    st_n.ena = 1'b1;
    // disable request
    if (ev_dis_done)                           st_n.dis = 1'b0;
    else if (cmd.dis_set && st_q.ena && !ev_clr) st_n.dis = 1'b1;
    // NAK: any set source outranks clear
    if (ev_setup || ev_xfer_done || cmd.nak_set) st_n.nak = 1'b1;
    else if (cmd.nak_clr)                        st_n.nak = 1'b0;
    // read/write fields
    if (cmd.wr) begin
      st_n.kind  = cmd.kind;
      st_n.stall = cmd.stall_val;
    end
    // PID / parity
    if (cmd.pid0_set)        st_n.pid = 1'b0;
    else if (cmd.pid1_set)   st_n.pid = 1'b1;
    else if (pid_toggle)     st_n.pid = ~st_q.pid;
  end

  assign st_en  = cmd.wr | ev_clr | pid_toggle;
  assign irq_en = ev_clr | irq_s_q | irq_x_q | irq_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '{ena: 1'b0, dis: 1'b0, nak: 1'b0, stall: 1'b0, pid: 1'b0, kind: EP_CTRL};
    end else if (st_en) begin
      st_q <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s_q <= 1'b0;
      irq_x_q <= 1'b0;
      irq_d_q <= 1'b0;
    end else if (irq_en) begin
      irq_s_q <= ev_setup;
      irq_x_q <= ev_xfer_done;
      irq_d_q <= ev_dis_done;
    end
  end

  assign st            = st_q;
  assign irq_setup     = irq_s_q;
  assign irq_xfer_done = irq_x_q;
  assign irq_ep_dis    = irq_d_q;

  assert_irq_after_ena_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_setup || irq_xfer_done || irq_ep_dis) |-> !st_q.ena);

  assert_dis_clear_before_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ep_dis |-> !st_q.dis);

  assert_dis_only_when_ena_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.dis) |-> $past(st_q.ena));

  assert_event_sets_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setup || ev_xfer_done) |=> st_q.nak);

  assert_stall_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.stall |-> kind_stallable(st_q.kind));

  assert_pid_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_ok && hs == HS_ACK && pid_match && !cmd.pid0_set && !cmd.pid1_set)
      |=> st_q.pid != $past(st_q.pid));

  assert_iso_parity_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.kind == EP_ISO && !cmd.wr) |=> $stable(st_q.pid));

endmodule

// File: rtl/usb_oep_ctrl.sv
module usb_oep_ctrl
  import usb_oep_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             glb_out_nak,
  input  logic             ev_setup,
  input  logic             ev_xfer_done,
  input  logic             ev_dis_done,
  input  logic             ev_data_ok,
  input  logic             pkt_pid,
  output logic             ep_enabled,
  output logic             ep_dis_pending,
  output logic             ep_nak,
  output logic             ep_stall,
  output logic             ep_pid,
  output logic [1:0]       hs_sel,
  output logic             data_keep,
  output logic             irq_setup,
  output logic             irq_xfer_done,
  output logic             irq_ep_dis
);

  sw_cmd_t   cmd;
  ep_state_t st;
  hs_t       hs;

  oep_reg_if #(.REG_W(REG_W)) u_regs (
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .st    (st),
    .cmd   (cmd),
    .rdata (cfg_rdata)
  );

  oep_state u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .ev_setup      (ev_setup),
    .ev_xfer_done  (ev_xfer_done),
    .ev_dis_done   (ev_dis_done),
    .ev_data_ok    (ev_data_ok),
    .pkt_pid       (pkt_pid),
    .hs            (hs),
    .st            (st),
    .irq_setup     (irq_setup),
    .irq_xfer_done (irq_xfer_done),
    .irq_ep_dis    (irq_ep_dis),
    .data_keep     (data_keep)
  );

  oep_hs_sel u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .glb_out_nak (glb_out_nak),
    .hs          (hs)
  );

  assign hs_sel         = hs;
  assign ep_enabled     = st.ena;
  assign ep_dis_pending = st.dis;
  assign ep_nak         = st.nak;
  assign ep_stall       = st.stall;
  assign ep_pid         = st.pid;

endmodule

// File: tb/usb_oep_ctrl_tb.sv
module usb_oep_ctrl_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cfg_rdata;
  logic         glb_out_nak = 1'b0;
  logic         ev_setup = 1'b0, ev_xfer_done = 1'b0, ev_dis_done = 1'b0, ev_data_ok = 1'b0;
  logic         pkt_pid = 1'b0;
  logic         ep_enabled, ep_dis_pending, ep_nak, ep_stall, ep_pid, data_keep;
  logic [1:0]   hs_sel;
  logic         irq_setup, irq_xfer_done, irq_ep_dis;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_oep_ctrl #(.REG_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .glb_out_nak(glb_out_nak), .ev_setup(ev_setup), .ev_xfer_done(ev_xfer_done),
    .ev_dis_done(ev_dis_done), .ev_data_ok(ev_data_ok), .pkt_pid(pkt_pid),
    .ep_enabled(ep_enabled), .ep_dis_pending(ep_dis_pending), .ep_nak(ep_nak),
    .ep_stall(ep_stall), .ep_pid(ep_pid), .hs_sel(hs_sel), .data_keep(data_keep),
    .irq_setup(irq_setup), .irq_xfer_done(irq_xfer_done), .irq_ep_dis(irq_ep_dis)
  );

  // Behavioural reference model
  int m_ena, m_dis, m_nak, m_stall, m_pid, m_kind;
  int m_irq_s, m_irq_x, m_irq_d;

  function automatic int exp_hs();
    if (m_kind == 1) return 0;
    if (m_stall != 0) return 3;
    if (m_nak != 0 || glb_out_nak || m_ena == 0) return 2;
    return 1;
  endfunction

  function automatic int exp_keep();
    if (!ev_data_ok) return 0;
    if (m_kind == 1) return m_ena;
    return (exp_hs() == 1 && int'(pkt_pid) == m_pid) ? 1 : 0;
  endfunction

  function automatic int exp_rdata();
    return m_ena | (m_dis << 1) | (m_stall << 4) | (m_nak << 7) | (m_kind << 8) | (m_pid << 10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ena = 0; m_dis = 0; m_nak = 0; m_stall = 0; m_pid = 0; m_kind = 0;
      m_irq_s = 0; m_irq_x = 0; m_irq_d = 0;
    end else begin
      int keep, ena0, evc;
      keep = exp_keep();
      ena0 = m_ena;
      evc  = (ev_setup || ev_xfer_done || ev_dis_done) ? 1 : 0;
      if (evc != 0) m_ena = 0;
      else if (cfg_wr && cfg_wdata[0]) m_ena = 1;
      if (ev_dis_done) m_dis = 0;
      else if (cfg_wr && cfg_wdata[1] && ena0 != 0 && evc == 0) m_dis = 1;
      if (ev_setup || ev_xfer_done || (cfg_wr && cfg_wdata[2])) m_nak = 1;
      else if (cfg_wr && cfg_wdata[3]) m_nak = 0;
      if (cfg_wr && cfg_wdata[5]) m_pid = 0;
      else if (cfg_wr && cfg_wdata[6]) m_pid = 1;
      else if (keep != 0 && m_kind != 1) m_pid = 1 - m_pid;
      if (cfg_wr) begin
        m_kind  = int'(cfg_wdata[9:8]);
        m_stall = (cfg_wdata[4] && m_kind >= 2) ? 1 : 0;
      end
      m_irq_s = ev_setup; m_irq_x = ev_xfer_done; m_irq_d = ev_dis_done;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 enable", ep_enabled, m_ena);
      chk("R3 disable request", ep_dis_pending, m_dis);
      chk("R4 nak", ep_nak, m_nak);
      chk("R6 stall", ep_stall, m_stall);
      chk("R8 pid", ep_pid, m_pid);
      chk("R7 handshake", hs_sel, exp_hs());
      chk("R10 keep", data_keep, exp_keep());
      chk("R4 status word", cfg_rdata, exp_rdata());
      chk("R5 irq setup", irq_setup, m_irq_s);
      chk("R2 irq xfer", irq_xfer_done, m_irq_x);
      chk("R3 irq disabled", irq_ep_dis, m_irq_d);
    end
  end

  // drive one cycle of inputs
  task automatic step(bit wr, logic [W-1:0] wd, bit s, bit x, bit d, bit dat, bit pid);
    @(posedge clk); #2;
    cfg_wr = wr; cfg_wdata = wd; ev_setup = s; ev_xfer_done = x;
    ev_dis_done = d; ev_data_ok = dat; pkt_pid = pid;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [W-1:0] wd);
    step(1, wd, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic pkt(bit pid);
    step(0, '0, 0, 0, 0, 1, pid);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status word", cfg_rdata, 0);
    chk("R1 handshake", hs_sel, 2);
    chk("R1 irq", irq_setup | irq_xfer_done | irq_ep_dis | data_keep, 0);

    wr(16'h0200);                 // bulk, disabled
    @(negedge clk); chk("R7 disabled naks", hs_sel, 2);
    wr(16'h0201);                 // enable
    @(negedge clk); chk("R7 ack", hs_sel, 1);
    wr(16'h0200);                 // writing 0 keeps enable
    @(negedge clk); chk("R2 write0 keeps", ep_enabled, 1);
    wr(16'h0204);
    @(negedge clk); chk("R4 set nak", ep_nak, 1);
    wr(16'h0208);
    @(negedge clk); chk("R4 clear nak", ep_nak, 0);
    wr(16'h020C);
    @(negedge clk); chk("R4 both nak", ep_nak, 1);
    chk("R4 cmd bits read 0", int'(cfg_rdata[3:2]), 0);
    wr(16'h0208);
    glb_out_nak = 1'b1;
    @(negedge clk); chk("R7 global nak", hs_sel, 2);
    wr(16'h0214);                 // stall + nak, global nak on
    @(negedge clk); chk("R6 stall wins", hs_sel, 3);
    glb_out_nak = 1'b0;
    wr(16'h0208);                 // stall off, nak off
    @(negedge clk); chk("R6 stall cleared", hs_sel, 1);

    // R10 PID tracking
    pkt(0); @(negedge clk); chk("R10 toggled", ep_pid, 1);
    step(0, '0, 0, 0, 0, 1, 0);
    @(negedge clk); chk("R10 mismatch dropped", data_keep, 0);
    chk("R10 mismatch acked", hs_sel, 1);
    idle(); @(negedge clk); chk("R10 no toggle", ep_pid, 1);
    pkt(1); @(negedge clk); chk("R10 toggled back", ep_pid, 0);
    wr(16'h0240); @(negedge clk); chk("R8 set data1", ep_pid, 1);
    wr(16'h0260); @(negedge clk); chk("R8 both data0", ep_pid, 0);
    step(1, 16'h0240, 0, 0, 0, 1, 0);   // command beats toggle
    idle(); @(negedge clk); chk("R8 cmd over toggle", ep_pid, 1);
    wr(16'h0204);
    pkt(1); @(negedge clk); chk("R10 nak no toggle", ep_pid, 1);
    wr(16'h0208);

    // R2/R5 events
    step(0, '0, 0, 1, 0, 0, 0); idle();
    @(negedge clk); chk("R2 xfer clears enable", ep_enabled, 0);
    chk("R5 xfer sets nak", ep_nak, 1);
    wr(16'h0209);
    step(1, 16'h0208, 1, 0, 0, 0, 0); idle();
    @(negedge clk); chk("R5 setup beats clear", ep_nak, 1);
    chk("R2 setup clears enable", ep_enabled, 0);

    // R3 disable request
    wr(16'h0202); @(negedge clk); chk("R3 ignored while disabled", ep_dis_pending, 0);
    wr(16'h0201); wr(16'h0202);
    @(negedge clk); chk("R3 set while enabled", ep_dis_pending, 1);
    step(0, '0, 0, 0, 1, 0, 0); idle();
    @(negedge clk); chk("R3 cleared", ep_dis_pending | ep_enabled, 0);
    wr(16'h0201);
    step(1, 16'h0202, 0, 1, 0, 0, 0); idle();
    @(negedge clk); chk("R3 event blocks request", ep_dis_pending, 0);

    // R6 stall on other kinds, R9 isochronous
    wr(16'h0011); @(negedge clk); chk("R6 control no stall", ep_stall, 0);
    wr(16'h0311); @(negedge clk); chk("R6 interrupt stall", hs_sel, 3);
    wr(16'h0111); @(negedge clk); chk("R6 iso no stall", ep_stall, 0);
    chk("R7 iso none", hs_sel, 0);
    wr(16'h0140); @(negedge clk); chk("R9 odd", ep_pid, 1);
    pkt(1); @(negedge clk); chk("R9 parity held", ep_pid, 1);
    step(0, '0, 0, 0, 0, 1, 0);
    @(negedge clk); chk("R9 iso keep", data_keep, 1);
    idle(); @(negedge clk); chk("R9 parity held 2", ep_pid, 1);
    wr(16'h0120); @(negedge clk); chk("R9 even", ep_pid, 0);
    step(0, '0, 1, 0, 0, 0, 0); idle();
    step(0, '0, 0, 0, 0, 1, 0);
    @(negedge clk); chk("R9 disabled iso drop", data_keep, 0);
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule